// File: doc/BRIEF.md
# Multiply-Accumulate Product and Saturation Stage

This block sits in front of the accumulate adder of a multiply-accumulate datapath. It owns four 64-bit accumulator registers and a small status word. A product request multiplies two 32-bit operands into a 64-bit value and then applies the overflow or rounding policy of the selected arithmetic mode. Signed integer, unsigned integer and signed fractional modes are supported. A saturate request takes one accumulator, tests it against the range of the chosen mode, clamps or wraps it, and writes it back.

When the overflow-mode-control bit is set, an overflowing product is replaced by a sentinel lying far beyond the 48-bit accumulator range, so the following accumulation is certain to overflow as well. Fractional products are rounded to nearest, with ties going to the even value. Accumulators can be loaded directly, and one can be copied onto another. Status writes set and clear the control bits and the sticky overflow flags.

Every request returns its result one cycle later on a registered output.

Top module: `mac_prod_sat`

## Requirements
- R1: A request accepted on a clock edge shows `res_valid` high with its result after that edge. With no request, `res_valid` is low and `res_data` is zero. Reset clears the status, all accumulators and the result. Operation codes: 0 product, 1 saturate, 2 move, 3 status write, 4 load. Codes 5 to 7 change no state and return zero.
- R2: Product in mode 0 (signed integer) forms the signed 64-bit product. If it does not fit in 40-bit signed, V is set. With OMC the result is then 2^50 for a non-negative product and the bitwise inverse of 2^50 for a negative one. Without OMC it is the low 40 bits sign-extended. A product that fits is returned unchanged.
- R3: Product in mode 1 (unsigned integer) forms the unsigned product. If any bit 63..40 is set, V is set, and the result is 2^50 with OMC or the low 40 bits without OMC.
- R4: Product in mode 2 (signed fractional; mode 3 behaves the same) with RT clear returns the signed product arithmetically shifted right by 24, and never changes V.
- R5: With RT set, a fractional product whose 24 dropped bits exceed 0x800000 rounds up by one. At exactly 0x800000 it adds the least significant bit of the shifted value.
- R6: Saturate in mode 0 sets V when the accumulator does not equal the sign extension of its low 48 bits. With V and OMC the result is 0x7FFFFFFF for a non-negative 48-bit view, and 0xFFFFFFFF80000000 for a negative one. With V and no OMC the result is the 48-bit sign extension.
- R7: Saturate in mode 1 sets V when any bit 63..48 is set. With V and OMC the result is 0 if the value is above 2^53, otherwise 2^48-1. With V and no OMC it is the low 48 bits.
- R8: Saturate in mode 2 sets V as in R6. With V and OMC the result is 0x00007FFFFFFFFFFF or 0xFFFF800000000000 according to the sign of the 48-bit view. Otherwise the result is the 48-bit sign extension.
- R9: When V is set after a saturate, whether it was already set or set by that saturate, sticky bit k is set for accumulator k (status bit 3+k) and the clamp of R6 to R8 applies even to a value in range. The saturated value is written back to the accumulator.
- R10: Move (source `req_src`, destination `req_dst`) copies the source accumulator and its sticky bit to the destination and returns the copied value.
- R11: The status word holds V at bit 0, OMC at bit 1, RT at bit 2 and sticky bits at 6..3. V and the sticky bits are only cleared by a status write (or, for a sticky bit, a move). A status write loads `req_a[6:0]` and returns it.
- R12: Load writes `{req_b, req_a}` into accumulator `req_dst` and returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_mode | input | 2 | Arithmetic mode |
| req_a | input | 32 | First operand, low load half, status value |
| req_b | input | 32 | Second operand, high load half |
| req_dst | input | 2 | Accumulator to saturate, load or write |
| req_src | input | 2 | Source accumulator of a move |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_data | output | 64 | Result value |
| status | output | 7 | V, OMC, RT and four sticky overflow bits |

## Verification
The hardest situations to reach through the ports are saturations whose outcome depends on state left by earlier requests. One is a saturate of an in-range accumulator while V is already set, which must still clamp. Another is the unsigned clamp at exactly 2^53. The stimulus reaches both by loading accumulators directly with chosen 64-bit values, forcing the control bits with status writes, and chaining saturates without clearing V. Rounding ties are reached with operand pairs whose product has exactly 0x800000 in the dropped bits, with both odd and even shifted values and with a negative product.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
   localparam logic [2:0] OP_PROD = 3'd0;
   localparam logic [2:0] OP_SAT  = 3'd1;
   localparam logic [2:0] OP_MOVE = 3'd2;
   localparam logic [2:0] OP_STAT = 3'd3;
   localparam logic [2:0] OP_LOAD = 3'd4;

   localparam logic [1:0] MD_SINT = 2'd0;
   localparam logic [1:0] MD_UINT = 2'd1;
   localparam logic [1:0] MD_FRAC = 2'd2;

   localparam int ST_V       = 0;
   localparam int ST_OMC     = 1;
   localparam int ST_RT      = 2;
   localparam int ST_STICKY0 = 3;
endpackage

// File: rtl/mps_product.sv
module mps_product
   import mac_sat_pkg::*;
#(
   parameter int OP_W       = 32,
   parameter int SPROD_BITS = 40,
   parameter int SENT_BIT   = 50,
   parameter int FRAC_SHIFT = 24,
   parameter bit ROUND_EN   = 1'b1
) (
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   input  logic [1:0]        mode,
   input  logic              omc,
   input  logic              rt,
   output logic [2*OP_W-1:0] prod_val,
   output logic              prod_ovf
);
   localparam int PW = 2 * OP_W;
   localparam logic [PW-1:0] SENT = PW'(1) << SENT_BIT;
   localparam logic [FRAC_SHIFT-1:0] HALF = FRAC_SHIFT'(1) << (FRAC_SHIFT - 1);

   logic signed [PW-1:0] sprod;
   logic        [PW-1:0] uprod;
   logic        [PW-1:0] s_wrap;
   logic signed [PW-1:0] shifted;
   logic [FRAC_SHIFT-1:0] rem;
   logic                 inc;
   logic                 s_ovf, u_ovf;

   assign sprod  = $signed({{OP_W{op_a[OP_W-1]}}, op_a}) * $signed({{OP_W{op_b[OP_W-1]}}, op_b});
   assign uprod  = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
   assign s_wrap = {{(PW-SPROD_BITS){sprod[SPROD_BITS-1]}}, sprod[SPROD_BITS-1:0]};
   assign s_ovf  = (s_wrap != sprod);
   assign u_ovf  = |uprod[PW-1:SPROD_BITS];
   assign shifted = sprod >>> FRAC_SHIFT;
   assign rem     = sprod[FRAC_SHIFT-1:0];

   generate
      if (ROUND_EN) begin : g_round
         assign inc = rt & ((rem > HALF) | ((rem == HALF) & shifted[0]));
      end else begin : g_trunc
         assign inc = 1'b0;
      end
   endgenerate

   always_comb begin
      prod_ovf = 1'b0;
      case (mode)
         MD_SINT: begin
            prod_ovf = s_ovf;
            if (!s_ovf)   prod_val = sprod;
            else if (omc) prod_val = sprod[PW-1] ? ~SENT : SENT;
            else          prod_val = s_wrap;
         end
         MD_UINT: begin
            prod_ovf = u_ovf;
            if (u_ovf && omc) prod_val = SENT;
            else              prod_val = {{(PW-SPROD_BITS){1'b0}}, uprod[SPROD_BITS-1:0]};
         end
         default: prod_val = shifted + PW'(inc);
      endcase
   end
endmodule

// File: rtl/mps_saturate.sv
module mps_saturate
   import mac_sat_pkg::*;
#(
   parameter int PW              = 64,
   parameter int ACC_BITS        = 48,
   parameter int SINT_CLAMP_BITS = 32,
   parameter int USAT_LIMIT_BIT  = 53
) (
   input  logic [PW-1:0] acc_val,
   input  logic [1:0]    mode,
   input  logic          v_in,
   input  logic          omc,
   output logic [PW-1:0] sat_val,
   output logic          sat_ovf
);
   localparam logic [PW-1:0] SMAX_NARROW = (PW'(1) << (SINT_CLAMP_BITS - 1)) - PW'(1);
   localparam logic [PW-1:0] SMAX_ACC    = (PW'(1) << (ACC_BITS - 1)) - PW'(1);
   localparam logic [PW-1:0] UMAX_ACC    = (PW'(1) << ACC_BITS) - PW'(1);
   localparam logic [PW-1:0] ULIMIT      = PW'(1) << USAT_LIMIT_BIT;

   logic [PW-1:0] s_view;
   logic          s_neg;
   logic          v_eff;

   assign s_view = {{(PW-ACC_BITS){acc_val[ACC_BITS-1]}}, acc_val[ACC_BITS-1:0]};
   assign s_neg  = acc_val[ACC_BITS-1];
   assign sat_ovf = (mode == MD_UINT) ? (|acc_val[PW-1:ACC_BITS]) : (s_view != acc_val);
   assign v_eff  = v_in | sat_ovf;

   always_comb begin
      case (mode)
         MD_SINT: begin
            if (v_eff && omc) sat_val = {PW{s_neg}} ^ SMAX_NARROW;
            else              sat_val = s_view;
         end
         MD_UINT: begin
            if (!v_eff)  sat_val = acc_val;
            else if (omc) sat_val = (acc_val > ULIMIT) ? '0 : UMAX_ACC;
            else          sat_val = acc_val & UMAX_ACC;
         end
         default: begin
            if (v_eff && omc) sat_val = {PW{s_neg}} ^ SMAX_ACC;
            else              sat_val = s_view;
         end
      endcase
   end
endmodule

// File: rtl/mps_acc_bank.sv
module mps_acc_bank #(
   parameter int N_ACC = 4,
   parameter int W     = 64,
   localparam int IDX_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_data,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic [W-1:0]     rd_a_data,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [W-1:0]     rd_b_data
);
   logic [N_ACC-1:0][W-1:0] flat;

   generate
      for (genvar i = 0; i < N_ACC; i++) begin : g_ent
         logic [W-1:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               ent_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))  ent_q <= wr_data;
         end
         assign flat[i] = ent_q;
      end
   endgenerate

   assign rd_a_data = flat[rd_a_idx];
   assign rd_b_data = flat[rd_b_idx];
endmodule

// File: rtl/mac_prod_sat.sv
module mac_prod_sat
   import mac_sat_pkg::*;
#(
   parameter int OP_W            = 32,
   parameter int N_ACC           = 4,
   parameter int SPROD_BITS      = 40,
   parameter int ACC_BITS        = 48,
   parameter int SENT_BIT        = 50,
   parameter int FRAC_SHIFT      = 24,
   parameter int SINT_CLAMP_BITS = 32,
   parameter int USAT_LIMIT_BIT  = 53,
   parameter bit ROUND_EN        = 1'b1,
   localparam int PW    = 2 * OP_W,
   localparam int IDX_W = (N_ACC > 1) ? $clog2(N_ACC) : 1,
   localparam int ST_W  = ST_STICKY0 + N_ACC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [1:0]       req_mode,
   input  logic [OP_W-1:0]  req_a,
   input  logic [OP_W-1:0]  req_b,
   input  logic [IDX_W-1:0] req_dst,
   input  logic [IDX_W-1:0] req_src,
   output logic             res_valid,
   output logic [PW-1:0]    res_data,
   output logic [ST_W-1:0]  status
);
   generate
      if (SPROD_BITS >= PW || ACC_BITS >= PW || SENT_BIT >= PW - 1 ||
          USAT_LIMIT_BIT >= PW || SINT_CLAMP_BITS > ACC_BITS ||
          FRAC_SHIFT < 2 || FRAC_SHIFT >= PW || ST_W > OP_W) begin : g_bad_cfg
         $error("mac_prod_sat: inconsistent width parameters");
      end
   endgenerate

   logic [ST_W-1:0] status_q, status_d;
   logic [PW-1:0]   res_q, res_d;
   logic            valid_q;
   logic [PW-1:0]   prod_val, sat_val, acc_rd, src_rd, wr_data;
   logic            prod_ovf, sat_ovf, wr_en;

   mps_product #(
      .OP_W(OP_W), .SPROD_BITS(SPROD_BITS), .SENT_BIT(SENT_BIT),
      .FRAC_SHIFT(FRAC_SHIFT), .ROUND_EN(ROUND_EN)
   ) u_prod (
      .op_a(req_a), .op_b(req_b), .mode(req_mode),
      .omc(status_q[ST_OMC]), .rt(status_q[ST_RT]),
      .prod_val(prod_val), .prod_ovf(prod_ovf)
   );

   mps_saturate #(
      .PW(PW), .ACC_BITS(ACC_BITS), .SINT_CLAMP_BITS(SINT_CLAMP_BITS),
      .USAT_LIMIT_BIT(USAT_LIMIT_BIT)
   ) u_sat (
      .acc_val(acc_rd), .mode(req_mode), .v_in(status_q[ST_V]),
      .omc(status_q[ST_OMC]), .sat_val(sat_val), .sat_ovf(sat_ovf)
   );

   mps_acc_bank #(.N_ACC(N_ACC), .W(PW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(req_dst), .wr_data(wr_data),
      .rd_a_idx(req_dst), .rd_a_data(acc_rd), .rd_b_idx(req_src), .rd_b_data(src_rd)
   );

   always_comb begin
      status_d = status_q;
      res_d    = '0;
      wr_en    = 1'b0;
      wr_data  = '0;
      if (req_valid) begin
         case (req_op)
            OP_PROD: begin
               res_d = prod_val;
               if (prod_ovf) status_d[ST_V] = 1'b1;
            end
            OP_SAT: begin
               res_d   = sat_val;
               wr_en   = 1'b1;
               wr_data = sat_val;
               if (status_q[ST_V] || sat_ovf) begin
                  status_d[ST_V] = 1'b1;
                  status_d[ST_STICKY0 + int'(req_dst)] = 1'b1;
               end
            end
            OP_MOVE: begin
               res_d   = src_rd;
               wr_en   = 1'b1;
               wr_data = src_rd;
               status_d[ST_STICKY0 + int'(req_dst)] = status_q[ST_STICKY0 + int'(req_src)];
            end
            OP_STAT: begin
               status_d = req_a[ST_W-1:0];
               res_d[ST_W-1:0] = req_a[ST_W-1:0];
            end
            OP_LOAD: begin
               res_d   = {req_b, req_a};
               wr_en   = 1'b1;
               wr_data = {req_b, req_a};
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         res_q    <= '0;
         valid_q  <= 1'b0;
      end else begin
         status_q <= status_d;
         res_q    <= res_d;
         valid_q  <= req_valid;
      end
   end

   assign res_valid = valid_q;
   assign res_data  = res_q;
   assign status    = status_q;

   AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid); // R1
   AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && res_data == '0)); // R1
   AST_UPROD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PROD && req_mode == MD_UINT && !status[ST_OMC])
      |=> ((res_data >> SPROD_BITS) == '0)); // R3
   AST_SINT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_SAT && req_mode == MD_SINT && status[ST_OMC])
      |=> (!status[ST_V] || res_data == ((PW'(1) << (SINT_CLAMP_BITS - 1)) - PW'(1)) ||
           res_data == ~((PW'(1) << (SINT_CLAMP_BITS - 1)) - PW'(1)))); // R6
   AST_SAT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_SAT)
      |=> (!status[ST_V] || status[ST_STICKY0 + int'($past(req_dst))])); // R9
   AST_V_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_V] && !(req_valid && req_op == OP_STAT)) |=> status[ST_V]); // R11
   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && (req_op == OP_STAT || req_op == OP_MOVE))
      |=> ((status[ST_W-1:ST_STICKY0] & $past(status[ST_W-1:ST_STICKY0]))
           == $past(status[ST_W-1:ST_STICKY0]))); // R11
endmodule

// File: tb/mac_prod_sat_test.sv
module mac_prod_sat_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [1:0]  req_mode = '0;
   logic [31:0] req_a = '0, req_b = '0;
   logic [1:0]  req_dst = '0, req_src = '0;
   logic        res_valid;
   logic [63:0] res_data;
   logic [6:0]  status;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit started = 1'b0;
   string cur_tag = "R1";

   // reference model state
   logic [63:0] m_acc [4];
   logic        m_v = 0, m_omc = 0, m_rt = 0;
   logic [3:0]  m_st = '0;
   logic        exp_valid = 0;
   logic [63:0] exp_data = '0;
   string       exp_tag = "R1";

   mac_prod_sat uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_mode(req_mode), .req_a(req_a), .req_b(req_b), .req_dst(req_dst),
      .req_src(req_src), .res_valid(res_valid), .res_data(res_data), .status(status)
   );

   always #2 clk = ~clk;

   initial for (int i = 0; i < 4; i++) m_acc[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_acc[i] = '0;
         m_v = 0; m_omc = 0; m_rt = 0; m_st = '0;
         exp_valid = 0; exp_data = '0; exp_tag = "R1";
      end else begin
         exp_valid = req_valid;
         exp_data  = '0;
         exp_tag   = cur_tag;
         if (req_valid) begin
            case (req_op)
               3'd0: begin
                  longint sp, w, q;
                  logic [63:0] up;
                  logic [23:0] rem;
                  sp = longint'($signed(req_a)) * longint'($signed(req_b));
                  if (req_mode == 2'd0) begin
                     w = (sp <<< 24) >>> 24;
                     if (w != sp) begin
                        m_v = 1;
                        exp_data = m_omc ? (sp < 0 ? ~(64'd1 << 50) : (64'd1 << 50)) : w;
                     end else exp_data = sp;
                  end else if (req_mode == 2'd1) begin
                     up = {32'd0, req_a} * {32'd0, req_b};
                     if (up >= (64'd1 << 40)) begin
                        m_v = 1;
                        exp_data = m_omc ? (64'd1 << 50) : (up % (64'd1 << 40));
                     end else exp_data = up;
                  end else begin
                     q = sp >>> 24;
                     rem = sp[23:0];
                     if (m_rt) begin
                        if (rem > 24'h800000) q = q + 1;
                        else if (rem == 24'h800000) q = q + (q & 1);
                     end
                     exp_data = q;
                  end
               end
               3'd1: begin
                  logic [63:0] v;
                  longint s48;
                  bit ovf;
                  v = m_acc[req_dst];
                  s48 = (longint'(v) <<< 16) >>> 16;
                  if (req_mode == 2'd1) ovf = (v >= 64'h0001_0000_0000_0000);
                  else                  ovf = (s48 != longint'(v));
                  if (m_v || ovf) begin
                     m_v = 1;
                     m_st[req_dst] = 1;
                     if (req_mode == 2'd0)
                        exp_data = m_omc ? (s48 < 0 ? 64'hFFFF_FFFF_8000_0000 : 64'h7FFF_FFFF) : s48;
                     else if (req_mode == 2'd1)
                        exp_data = m_omc ? (v > 64'h0020_0000_0000_0000 ? 64'd0 : 64'h0000_FFFF_FFFF_FFFF)
                                         : (v & 64'h0000_FFFF_FFFF_FFFF);
                     else
                        exp_data = m_omc ? (s48 < 0 ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF) : s48;
                  end else exp_data = v;
                  m_acc[req_dst] = exp_data;
               end
               3'd2: begin
                  exp_data = m_acc[req_src];
                  m_acc[req_dst] = exp_data;
                  m_st[req_dst] = m_st[req_src];
               end
               3'd3: begin
                  m_v = req_a[0]; m_omc = req_a[1]; m_rt = req_a[2]; m_st = req_a[6:3];
                  exp_data = {57'd0, req_a[6:0]};
               end
               3'd4: begin
                  exp_data = {req_b, req_a};
                  m_acc[req_dst] = exp_data;
               end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         logic [6:0] es;
         es = {m_st, m_rt, m_omc, m_v};
         checks++;
         if (res_valid !== exp_valid || res_data !== exp_data || status !== es) begin
            fails++;
            $display("FAIL %s: valid/data/status actual %b/%h/%h expected %b/%h/%h",
                     exp_tag, res_valid, res_data, status, exp_valid, exp_data, es);
         end
      end
   end

   task automatic do_op(input logic [2:0] op, input logic [1:0] md,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] d, input logic [1:0] s, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_mode = md;
      req_a = a; req_b = b; req_dst = d; req_src = s; cur_tag = tag;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; req_op = '0; req_a = '0; req_b = '0; cur_tag = "R1";
      end
   endtask

   task automatic load(input logic [1:0] d, input logic [63:0] v, input string tag);
      do_op(3'd4, 2'd0, v[31:0], v[63:32], d, 2'd0, tag);
   endtask

   task automatic stat(input logic [6:0] v, input string tag);
      do_op(3'd3, 2'd0, {25'd0, v}, 32'd0, 2'd0, 2'd0, tag);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL R1: watchdog expired, actual running expected finished");
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      started = 1'b1;
      repeat (3) @(negedge clk);   // reset state checks (R1)
      rst_n = 1'b1;
      idle(2);
      // R11: status write
      stat(7'h00, "R11");
      // R2: signed products
      do_op(3'd0, 2'd0, 32'd1000, 32'hFFFF_FFFD, 0, 0, "R2");
      do_op(3'd0, 2'd0, 32'h4000_0000, 32'h4000_0000, 0, 0, "R2");
      do_op(3'd0, 2'd0, 32'h0012_3456, 32'h0003_0001, 0, 0, "R11");
      stat(7'h02, "R11");
      do_op(3'd0, 2'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, "R2");
      do_op(3'd0, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R2");
      // R3: unsigned products
      stat(7'h02, "R11");
      do_op(3'd0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R3");
      stat(7'h00, "R11");
      do_op(3'd0, 2'd1, 32'hFFFF_FFFF, 32'h0001_2345, 0, 0, "R3");
      stat(7'h00, "R11");
      do_op(3'd0, 2'd1, 32'h8000_0000, 32'h0000_00FF, 0, 0, "R3");
      // R4: fractional truncation
      do_op(3'd0, 2'd2, 32'h00C0_0000, 32'd3, 0, 0, "R4");
      do_op(3'd0, 2'd2, 32'hFE80_0000, 32'd1, 0, 0, "R4");
      do_op(3'd0, 2'd3, 32'h0180_0000, 32'd1, 0, 0, "R4");
      // R5: rounding
      stat(7'h04, "R11");
      do_op(3'd0, 2'd2, 32'h0180_0000, 32'd1, 0, 0, "R5");
      do_op(3'd0, 2'd2, 32'h0280_0000, 32'd1, 0, 0, "R5");
      do_op(3'd0, 2'd2, 32'h0180_0001, 32'd1, 0, 0, "R5");
      do_op(3'd0, 2'd2, 32'h017F_FFFF, 32'd1, 0, 0, "R5");
      do_op(3'd0, 2'd2, 32'hFE80_0000, 32'd1, 0, 0, "R5");
      do_op(3'd0, 2'd2, 32'h1234_5678, 32'h0ABC_DEF1, 0, 0, "R5");
      // R12 loads, R6 signed saturation
      stat(7'h02, "R11");
      load(0, 64'h0000_7FFF_FFFF_FFFF, "R12");
      load(1, 64'h0001_0000_0000_0000, "R12");
      load(2, 64'hFF00_8000_0000_0000, "R12");
      do_op(3'd1, 2'd0, 0, 0, 0, 0, "R6");
      do_op(3'd1, 2'd0, 0, 0, 1, 0, "R6");
      do_op(3'd1, 2'd0, 0, 0, 2, 0, "R6");
      // R9: V already set clamps an in-range value
      load(0, 64'h0000_0000_0000_1234, "R12");
      do_op(3'd1, 2'd0, 0, 0, 0, 0, "R9");
      stat(7'h00, "R11");
      load(3, 64'hFFF0_0000_0000_0007, "R12");
      do_op(3'd1, 2'd0, 0, 0, 3, 0, "R6");
      // R7: unsigned saturation
      stat(7'h00, "R11");
      load(3, 64'h0001_0000_0000_0005, "R12");
      do_op(3'd1, 2'd1, 0, 0, 3, 0, "R7");
      stat(7'h02, "R11");
      load(3, 64'h0040_0000_0000_0001, "R12");
      do_op(3'd1, 2'd1, 0, 0, 3, 0, "R7");
      stat(7'h02, "R11");
      load(2, 64'h0020_0000_0000_0000, "R12");
      do_op(3'd1, 2'd1, 0, 0, 2, 0, "R7");
      stat(7'h02, "R11");
      load(1, 64'h0000_1234_5678_9ABC, "R12");
      do_op(3'd1, 2'd1, 0, 0, 1, 0, "R7");
      // R8: fractional saturation
      stat(7'h02, "R11");
      load(0, 64'h0123_4567_89AB_CDEF, "R12");
      do_op(3'd1, 2'd2, 0, 0, 0, 0, "R8");
      stat(7'h02, "R11");
      load(0, 64'h00FF_8000_0000_0000, "R12");
      do_op(3'd1, 2'd2, 0, 0, 0, 0, "R8");
      stat(7'h00, "R11");
      load(0, 64'h0001_0000_0000_0042, "R12");
      do_op(3'd1, 2'd2, 0, 0, 0, 0, "R8");
      // R10: moves with sticky copy
      stat(7'h10, "R11");
      load(1, 64'hDEAD_BEEF_0BAD_F00D, "R12");
      do_op(3'd2, 2'd0, 0, 0, 2, 1, "R10");
      do_op(3'd2, 2'd0, 0, 0, 1, 3, "R10");
      do_op(3'd2, 2'd0, 0, 0, 3, 2, "R10");
      // R1: unused op codes change nothing
      do_op(3'd5, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 2, "R1");
      do_op(3'd7, 2'd1, 32'h7F, 32'h1, 0, 0, "R1");
      do_op(3'd2, 2'd0, 0, 0, 0, 2, "R10");
      idle(3);
      done = 1'b1;
      finish_run();
   end
endmodule